// File: doc/BRIEF.md
# Virtual-Channel Input Unit with Credit Accounting

This block is the receive side of one physical router channel that carries several virtual channels (VCs). Each VC has its own small flit queue and a wormhole state record: idle or active, plus the output port and downstream VC that its current packet was bound to. A flit arrives tagged with its VC number and a two-bit kind. Only a head flit carries routing intent. Body and tail flits follow whatever binding their head received. A tail releases the VC.

An external allocator decides routes and grants. This block only accepts its decisions. A bind strobe names a VC, an output port and a downstream VC. A select input names which VC may use the outgoing channel this cycle. When a VC's queue is empty, an arriving flit is offered to the output in the same cycle. It is stored only if it cannot leave. The block keeps one credit counter per downstream VC and never sends into a VC whose counter is zero. Upstream, it returns one credit for every flit that leaves.

Back-pressure: the output is valid/ready. A flit transfers on a cycle with `out_valid` and `out_ready` both high. While `out_ready` is low, the offered flit and its route stay put. The input side has no ready: the sender may only send while it holds a credit for that VC.

Top module: `vc_input_port`

## Requirements
- R1: After reset, every VC is idle with an empty queue, `out_valid`, `credit_out_valid` and `err_overflow` are 0, and every downstream credit counter holds `DN_DEPTH`.
- R2: A bind strobe takes effect only for an idle VC whose front flit is a head (kind bit 0 set). The head may leave in that same cycle. A bind strobe for an active VC, or for a VC with no head at its front, is ignored.
- R3: Every flit of a packet leaves with the `out_port`/`out_ovc` bound at its head.
- R4: Forwarding a flit whose kind bit 1 is set (tail `10`, or single-flit `11`) returns its VC to idle. Kind encodings: `00` body, `01` head, `10` tail, `11` head and tail.
- R5: `out_valid` is high only when all three hold for the VC named by `sel_vc`: it has a front flit, it has a bound route, and the credit counter of that route's downstream VC is nonzero.
- R6: A downstream credit counter decrements on each flit sent to its VC and increments on each `credit_in_valid` strobe naming that VC. Both in one cycle leave it unchanged.
- R7: A flit arriving at an empty queue is offered at the output in its arrival cycle. It is written into the queue only if it does not leave in that cycle.
- R8: Flits of one VC leave in arrival order. None is lost, duplicated or overtaken.
- R9: One cycle after each forwarded flit, `credit_out_valid` pulses with `credit_out_vc` naming the VC it left. It never pulses otherwise.
- R10: A flit arriving at a VC whose queue already holds `DEPTH` flits is dropped, and `err_overflow` goes high and stays high until reset.
- R11: With `out_ready` low, the offered flit is held, and it is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming flit strobe |
| in_vc | input | VC_W | VC of incoming flit |
| in_kind | input | 2 | Flit kind (00 body, 01 head, 10 tail, 11 single) |
| in_data | input | DATA_W | Flit payload |
| credit_out_valid | output | 1 | Credit returned to upstream sender |
| credit_out_vc | output | VC_W | VC the returned credit belongs to |
| bind_valid | input | 1 | Allocator binds a route to a VC |
| bind_vc | input | VC_W | VC being bound |
| bind_port | input | PORT_W | Output port granted |
| bind_ovc | input | OVC_W | Downstream VC granted |
| sel_vc | input | VC_W | VC granted the channel this cycle |
| out_valid | output | 1 | A flit is offered |
| out_ready | input | 1 | Channel accepts the flit |
| out_kind | output | 2 | Kind of offered flit |
| out_data | output | DATA_W | Payload of offered flit |
| out_port | output | PORT_W | Output port bound to the flit's packet |
| out_ovc | output | OVC_W | Downstream VC bound to the flit's packet |
| out_vc | output | VC_W | Local VC the flit comes from |
| credit_in_valid | input | 1 | Downstream credit strobe |
| credit_in_vc | input | OVC_W | Downstream VC that freed a slot |
| err_overflow | output | 1 | Sticky flag: flit arrived at a full queue |

## Verification
The bench goes after the following corner cases:
- **Same-cycle bind and send of a single-flit packet through the bypass.** If release did not take priority over bind, the VC would stay active and the next head would skip allocation.
- **A head that misses its slot.** It must land in the queue. A design that dropped it or sent it twice would miscompare on the payload order.
- **Downstream credits running dry.** A counter that went to zero late or wrapped would show `out_valid` while the model expects a stall. A missing credit return upstream would starve the random traffic.
- **A fifth flit into a four-deep queue.** It must set the sticky flag and vanish. If it overwrote a slot, an extra or changed flit would show up during the drain.

// File: rtl/vcin_pkg.sv
package vcin_pkg;

  typedef enum logic [1:0] {
    KIND_BODY   = 2'b00,
    KIND_HEAD   = 2'b01,
    KIND_TAIL   = 2'b10,
    KIND_SINGLE = 2'b11
  } flit_kind_e;

  function automatic logic kind_opens(input logic [1:0] k);
    return k[0];
  endfunction

  function automatic logic kind_closes(input logic [1:0] k);
    return k[1];
  endfunction

endpackage

// File: rtl/vcin_flit_fifo.sv
module vcin_flit_fifo #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step_ptr(wr_ptr);
      if (pop)  rd_ptr <= step_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));

  // R8: occupancy follows pushes and pops exactly
  assert_fifo_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count == $past(count) + 1'b1));
  assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/vcin_vc_state.sv
module vcin_vc_state #(
  parameter int PORT_W = 3,
  parameter int OVC_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bind_en,
  input  logic [PORT_W-1:0] bind_port,
  input  logic [OVC_W-1:0]  bind_ovc,
  input  logic              release_en,
  output logic              active,
  output logic [PORT_W-1:0] port,
  output logic [OVC_W-1:0]  ovc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      port   <= '0;
      ovc    <= '0;
    end else if (release_en) begin
      active <= 1'b0;
    end else if (bind_en) begin
      active <= 1'b1;
      port   <= bind_port;
      ovc    <= bind_ovc;
    end
  end

  // R4: a forwarded tail leaves the VC idle
  assert_release_on_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    release_en |=> !active);
  // R3: the route stays fixed while the packet is in flight
  assert_route_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !release_en) |=> (port == $past(port) && ovc == $past(ovc)));
endmodule

// File: rtl/vcin_credit_ctr.sv
module vcin_credit_ctr #(
  parameter int MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic nonzero
);
  localparam int CNT_W = $clog2(MAX + 1);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= CNT_W'(MAX);
    end else begin
      case ({inc, dec})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign nonzero = (count != '0);

  // R5: nothing is sent into a downstream VC with no free slot
  assert_no_send_at_zero_credit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (count != '0));
  // R6: returned credits never exceed the downstream depth
  assert_credit_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec) |-> (count != CNT_W'(MAX)));
endmodule

// File: rtl/vc_input_port.sv
module vc_input_port #(
  parameter int NUM_VC    = 2,
  parameter int DEPTH     = 4,
  parameter int DATA_W    = 16,
  parameter int NUM_PORTS = 5,
  parameter int NUM_OVC   = 2,
  parameter int DN_DEPTH  = 4,
  localparam int VC_W     = $clog2(NUM_VC),
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int OVC_W    = $clog2(NUM_OVC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [VC_W-1:0]   in_vc,
  input  logic [1:0]        in_kind,
  input  logic [DATA_W-1:0] in_data,
  output logic              credit_out_valid,
  output logic [VC_W-1:0]   credit_out_vc,
  input  logic              bind_valid,
  input  logic [VC_W-1:0]   bind_vc,
  input  logic [PORT_W-1:0] bind_port,
  input  logic [OVC_W-1:0]  bind_ovc,
  input  logic [VC_W-1:0]   sel_vc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [DATA_W-1:0] out_data,
  output logic [PORT_W-1:0] out_port,
  output logic [OVC_W-1:0]  out_ovc,
  output logic [VC_W-1:0]   out_vc,
  input  logic              credit_in_valid,
  input  logic [OVC_W-1:0]  credit_in_vc,
  output logic              err_overflow
);
  import vcin_pkg::*;

  localparam int FLIT_W = DATA_W + 2;

  logic [FLIT_W-1:0] q_rdata    [NUM_VC];
  logic [FLIT_W-1:0] front_flit [NUM_VC];
  logic [PORT_W-1:0] st_port    [NUM_VC];
  logic [OVC_W-1:0]  st_ovc     [NUM_VC];
  logic [PORT_W-1:0] rt_port    [NUM_VC];
  logic [OVC_W-1:0]  rt_ovc     [NUM_VC];
  logic [NUM_VC-1:0] q_empty, q_full, arrive, front_valid, st_active;
  logic [NUM_VC-1:0] bind_hit, routed, go, push, pop, release_vc, ovf;
  logic [NUM_OVC-1:0] cr_nonzero, cr_inc, cr_dec;
  logic fire, sel_ok;

  // per-VC queue, state and front-of-line selection
  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    assign arrive[v]      = in_valid && (in_vc == VC_W'(v));
    assign front_valid[v] = !q_empty[v] || arrive[v];
    assign front_flit[v]  = q_empty[v] ? {in_kind, in_data} : q_rdata[v];
    assign bind_hit[v]    = bind_valid && (bind_vc == VC_W'(v)) && !st_active[v]
                            && front_valid[v] && kind_opens(front_flit[v][FLIT_W-1 -: 2]);
    assign routed[v]      = st_active[v] || bind_hit[v];
    assign rt_port[v]     = st_active[v] ? st_port[v] : bind_port;
    assign rt_ovc[v]      = st_active[v] ? st_ovc[v]  : bind_ovc;

    assign go[v]          = fire && (sel_vc == VC_W'(v));
    assign pop[v]         = go[v] && !q_empty[v];
    assign push[v]        = arrive[v] && !q_full[v] && !(go[v] && q_empty[v]);
    assign ovf[v]         = arrive[v] && q_full[v];
    assign release_vc[v]  = go[v] && kind_closes(front_flit[v][FLIT_W-1 -: 2]);

    vcin_flit_fifo #(.WIDTH(FLIT_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push[v]),
      .pop   (pop[v]),
      .wdata ({in_kind, in_data}),
      .rdata (q_rdata[v]),
      .empty (q_empty[v]),
      .full  (q_full[v])
    );

    vcin_vc_state #(.PORT_W(PORT_W), .OVC_W(OVC_W)) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .bind_en    (bind_hit[v]),
      .bind_port  (bind_port),
      .bind_ovc   (bind_ovc),
      .release_en (release_vc[v]),
      .active     (st_active[v]),
      .port       (st_port[v]),
      .ovc        (st_ovc[v])
    );
  end

  // downstream credit counters, one per downstream VC
  for (genvar o = 0; o < NUM_OVC; o++) begin : g_credit
    assign cr_dec[o] = fire && (out_ovc == OVC_W'(o));
    assign cr_inc[o] = credit_in_valid && (credit_in_vc == OVC_W'(o));

    vcin_credit_ctr #(.MAX(DN_DEPTH)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (cr_inc[o]),
      .dec     (cr_dec[o]),
      .nonzero (cr_nonzero[o])
    );
  end

  // output channel: the granted VC offers its front flit
  assign sel_ok   = (int'(sel_vc) < NUM_VC);
  assign out_vc   = sel_vc;
  assign out_kind = front_flit[sel_vc][FLIT_W-1 -: 2];
  assign out_data = front_flit[sel_vc][DATA_W-1:0];
  assign out_port = rt_port[sel_vc];
  assign out_ovc  = rt_ovc[sel_vc];
  assign out_valid = sel_ok && front_valid[sel_vc] && routed[sel_vc]
                     && cr_nonzero[rt_ovc[sel_vc]];
  assign fire     = out_valid && out_ready;

  // upstream credit return and overflow flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credit_out_valid <= 1'b0;
      credit_out_vc    <= '0;
      err_overflow     <= 1'b0;
    end else begin
      credit_out_valid <= fire;
      credit_out_vc    <= sel_vc;
      if (|ovf) err_overflow <= 1'b1;
    end
  end

  // R9: every departure gives back exactly one upstream credit
  assert_credit_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (credit_out_valid && credit_out_vc == $past(sel_vc)));
  assert_no_spurious_credit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !credit_out_valid);
  // R10: overflow raises the flag and it sticks
  assert_overflow_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf) |=> err_overflow);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |=> err_overflow);
  // R11: an offered flit that is not taken is still offered next cycle
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !q_empty[sel_vc]) |=>
      ($stable(sel_vc) && !credit_in_valid) |-> (out_data == $past(out_data)));
endmodule

// File: tb/vc_input_port_tb.sv
module vc_input_port_tb;
  localparam int NV = 2, DEP = 4, DW = 16, NP = 5, NO = 2, DN = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          in_valid, bind_valid, out_ready, credit_in_valid;
  logic [0:0]    in_vc, bind_vc, sel_vc, bind_ovc, credit_in_vc;
  logic [1:0]    in_kind;
  logic [DW-1:0] in_data;
  logic [2:0]    bind_port;
  logic          credit_out_valid, out_valid, err_overflow;
  logic [0:0]    credit_out_vc, out_vc, out_ovc;
  logic [1:0]    out_kind;
  logic [DW-1:0] out_data;
  logic [2:0]    out_port;

  vc_input_port #(.NUM_VC(NV), .DEPTH(DEP), .DATA_W(DW), .NUM_PORTS(NP),
                  .NUM_OVC(NO), .DN_DEPTH(DN)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc),
    .in_kind(in_kind), .in_data(in_data), .credit_out_valid(credit_out_valid),
    .credit_out_vc(credit_out_vc), .bind_valid(bind_valid), .bind_vc(bind_vc),
    .bind_port(bind_port), .bind_ovc(bind_ovc), .sel_vc(sel_vc),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_data(out_data), .out_port(out_port), .out_ovc(out_ovc), .out_vc(out_vc),
    .credit_in_valid(credit_in_valid), .credit_in_vc(credit_in_vc),
    .err_overflow(err_overflow)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [17:0] mq [NV][$];
  bit  m_act [NV];
  int  m_port [NV], m_ovc [NV], m_up [NV], gen_left [NV];
  int  m_dn [NO];
  bit  m_err;
  int  seq = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    in_valid = 0; in_vc = 0; in_kind = 0; in_data = 0;
    bind_valid = 0; bind_vc = 0; bind_port = 0; bind_ovc = 0;
    sel_vc = 0; out_ready = 0; credit_in_valid = 0; credit_in_vc = 0;
  endtask

  task automatic put(input int v, input logic [1:0] k);
    in_valid = 1; in_vc = v[0]; in_kind = k; in_data = DW'(16'h1000 + seq);
    seq++;
    m_up[v]--;
  endtask

  task automatic bindv(input int v, input int p, input int o);
    bind_valid = 1; bind_vc = v[0]; bind_port = p[2:0]; bind_ovc = o[0];
  endtask

  function automatic logic [1:0] next_kind(input int v);
    int len;
    if (gen_left[v] == 0) begin
      len = 1 + int'($urandom % 4);
      gen_left[v] = len - 1;
      return (len == 1) ? 2'b11 : 2'b01;
    end
    gen_left[v]--;
    return (gen_left[v] == 0) ? 2'b10 : 2'b00;
  endfunction

  // one clock: check combinational outputs, update model at the edge,
  // check registered outputs afterwards
  task automatic cycle();
    logic [17:0] fr [NV];
    bit fv [NV], bh [NV], rt [NV];
    int rp [NV], ro [NV];
    bit ev, efire, byp;
    int s;
    #2;
    for (int v = 0; v < NV; v++) begin
      if (mq[v].size() > 0) begin fv[v] = 1; fr[v] = mq[v][0]; end
      else if (in_valid && int'(in_vc) == v) begin fv[v] = 1; fr[v] = {in_kind, in_data}; end
      else begin fv[v] = 0; fr[v] = '0; end
      bh[v] = bind_valid && int'(bind_vc) == v && !m_act[v] && fv[v] && fr[v][16];
      rt[v] = m_act[v] || bh[v];
      rp[v] = m_act[v] ? m_port[v] : int'(bind_port);
      ro[v] = m_act[v] ? m_ovc[v]  : int'(bind_ovc);
    end
    s  = int'(sel_vc);
    ev = fv[s] && rt[s] && (m_dn[ro[s]] > 0);
    chk(out_valid == ev, "R5", "out_valid (R2 R4 R6 gating)", out_valid, ev);
    if (ev && out_valid) begin
      byp = (mq[s].size() == 0);
      chk(out_data == fr[s][15:0], byp ? "R7" : "R8", "out_data (R11 hold)",
          out_data, fr[s][15:0]);
      chk(out_kind == fr[s][17:16], "R8", "out_kind", out_kind, fr[s][17:16]);
      chk(int'(out_port) == rp[s], "R3", "out_port (R2 bind)", out_port, rp[s]);
      chk(int'(out_ovc) == ro[s], "R3", "out_ovc", out_ovc, ro[s]);
    end
    efire = ev && out_ready;
    byp   = efire && (mq[s].size() == 0);
    @(posedge clk);
    for (int v = 0; v < NV; v++)
      if (bh[v]) begin m_act[v] = 1; m_port[v] = rp[v]; m_ovc[v] = ro[v]; end
    if (in_valid && !(byp && int'(in_vc) == s)) begin
      if (mq[in_vc].size() >= DEP) m_err = 1;
      else mq[in_vc].push_back({in_kind, in_data});
    end
    if (efire) begin
      if (!byp) void'(mq[s].pop_front());
      if (fr[s][17]) m_act[s] = 0;
      m_dn[ro[s]]--;
    end
    if (credit_in_valid) m_dn[credit_in_vc]++;
    #2;
    chk(credit_out_valid == efire, "R9", "credit_out_valid", credit_out_valid, efire);
    if (efire) chk(int'(credit_out_vc) == s, "R9", "credit_out_vc", credit_out_vc, s);
    chk(err_overflow == m_err, "R10", "err_overflow", err_overflow, m_err);
    if (credit_out_valid) m_up[credit_out_vc]++;
    @(negedge clk);
  endtask

  task automatic return_random_credit();
    int o;
    o = int'($urandom % NO);
    if (m_dn[o] < DN && ($urandom % 3) == 0) begin
      credit_in_valid = 1; credit_in_vc = o[0];
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    for (int v = 0; v < NV; v++) begin
      m_act[v] = 0; m_port[v] = 0; m_ovc[v] = 0; m_up[v] = DEP; gen_left[v] = 0;
    end
    for (int o = 0; o < NO; o++) m_dn[o] = DN;
    m_err = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    #2;
    chk(out_valid == 0, "R1", "reset out_valid", out_valid, 0);
    chk(credit_out_valid == 0, "R1", "reset credit_out_valid", credit_out_valid, 0);
    chk(err_overflow == 0, "R1", "reset err_overflow", err_overflow, 0);
    @(negedge clk);
    rst_n = 1;

    // single-flit packet bound and bypassed in one cycle (R2 R4 R7)
    idle_inputs(); put(0, 2'b11); bindv(0, 3, 1); sel_vc = 0; out_ready = 1;
    cycle();
    idle_inputs(); sel_vc = 0; out_ready = 1;
    cycle();
    #2; chk(out_valid == 0, "R4", "VC idle after single-flit packet", out_valid, 0);

    // head misses its slot, is stored, bound later; body/tail inherit (R2 R3 R7 R11)
    idle_inputs(); put(1, 2'b01); sel_vc = 1; out_ready = 1; cycle();
    idle_inputs(); bindv(1, 2, 0); sel_vc = 1; out_ready = 0; cycle();
    idle_inputs(); bindv(1, 4, 1); sel_vc = 1; out_ready = 0; put(1, 2'b00); cycle();
    idle_inputs(); sel_vc = 1; out_ready = 1; put(1, 2'b10); cycle();
    for (int i = 0; i < 3; i++) begin
      idle_inputs(); sel_vc = 1; out_ready = 1; bindv(1, 1, 1); cycle();
    end

    // exhaust downstream VC 0, then free one slot (R5 R6)
    for (int i = 0; i < 8; i++) begin
      idle_inputs();
      if (m_dn[0] < DN) begin credit_in_valid = 1; credit_in_vc = 0; end
      if (m_dn[1] < DN && i > 3) begin credit_in_valid = 1; credit_in_vc = 1; end
      cycle();
    end
    for (int i = 0; i < 6; i++) begin
      idle_inputs(); if (m_up[0] > 0) put(0, 2'b11);
      bindv(0, 0, 0); sel_vc = 0; out_ready = 1; cycle();
    end
    idle_inputs(); sel_vc = 0; out_ready = 1; bindv(0, 0, 0);
    #2; chk(out_valid == 0, "R5", "stall at zero credit", out_valid, 0);
    credit_in_valid = 1; credit_in_vc = 0; cycle();
    for (int i = 0; i < 4; i++) begin
      idle_inputs(); sel_vc = 0; out_ready = 1; bindv(0, 0, 0);
      if (m_dn[0] < DN) begin credit_in_valid = 1; credit_in_vc = 0; end
      cycle();
    end

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      int v;
      idle_inputs();
      v = int'($urandom % NV);
      if (($urandom % 4) != 0 && m_up[v] > 0) put(v, next_kind(v));
      if (($urandom % 2) != 0)
        bindv(int'($urandom % NV), int'($urandom % NP), int'($urandom % NO));
      sel_vc = 1'($urandom % NV);
      out_ready = (($urandom % 4) != 0);
      return_random_credit();
      cycle();
    end

    // finish open packets, then drain
    for (int n = 0; n < 600; n++) begin
      int v;
      idle_inputs();
      v = n % NV;
      if (gen_left[v] > 0 && m_up[v] > 0) put(v, next_kind(v));
      if (($urandom % 2) != 0)
        bindv(int'($urandom % NV), int'($urandom % NP), int'($urandom % NO));
      sel_vc = 1'($urandom % NV);
      out_ready = 1;
      return_random_credit();
      cycle();
    end

    // overflow: five flits into VC 1 while it cannot drain (R10)
    idle_inputs(); cycle();
    for (int i = 0; i < 5; i++) begin
      idle_inputs(); put(1, (i == 0) ? 2'b01 : ((i == 4) ? 2'b10 : 2'b00));
      sel_vc = 0; out_ready = 0; cycle();
    end
    for (int i = 0; i < 10; i++) begin
      idle_inputs(); bindv(1, 1, 1); sel_vc = 1; out_ready = 1;
      if (m_dn[1] < DN) begin credit_in_valid = 1; credit_in_vc = 1; end
      cycle();
    end
    idle_inputs(); sel_vc = 1; out_ready = 1;
    #2;
    chk(out_valid == 0, "R10", "dropped flit never appears", out_valid, 0);
    chk(err_overflow == 1, "R10", "flag still set", err_overflow, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule